// File: doc/BRIEF.md
# Calendar Real-Time Clock with Field Alarm

This block is a register-mapped calendar clock. A reference tick input is divided by a programmable prescaler into a once-per-second step. Each step advances a chain of eight calendar counters: second, minute, hour, day of month, day of week, day of year, month and year. A carry out of one counter advances the next. Software reads and writes every counter at its own word address. It can also read the whole time at once as three packed words.

Eight alarm registers hold a target value for each field. A mask register removes fields from the comparison. A separate enable register chooses which fields raise an increment event when they change. The mask and the enable register use the same bit order:

| Bit | Field |
|-----|-------|
| 0 | second |
| 1 | minute |
| 2 | hour |
| 3 | day of month |
| 4 | day of week |
| 5 | day of year |
| 6 | month |
| 7 | year |

Both kinds of event land in a flag register that is cleared by writing 1. The interrupt line is the OR of the two flags.

A control register starts and stops counting and can hold the prescaler in reset. A small state machine in the prescaler follows the control register. Its states are:
- STOPPED: counting is off.
- HELD: the divider is forced to zero.
- RUNNING: the divider counts ticks.

Its transitions are:
- START: STOPPED to RUNNING.
- STOP: RUNNING to STOPPED.
- HOLD: any state to HELD.
- RELEASE: HELD to RUNNING, or HELD to STOPPED.

A calibration word is only stored and read back.

Software must write the second counter to 0 before it sets the other fields. Without this, a carry from the seconds counter could disturb the fields already written.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the counters read as follows: second 0, minute 0, hour 0, day of month 1, day of week 0, day of year 1, month 1, year 0. The alarm mask (0x10) reads 0xFF. The flag register (0x00), the increment enable register (0x0C) and the control register (0x08) read 0, and `irq` is low.
- R2: While control bit 0 is set and bit 1 is clear, the second counter (0x20) advances by one for every PRESCALE cycles in which `tick` is high. While control bit 0 is clear, no counter changes.
- R3: While control bit 1 is set, the divider is held at zero and no counter advances. Control bits 0, 1 and 4 are stored and read back at the same positions.
- R4: Roll-over limits are as follows:
  - Second and minute wrap from 59 to 0.
  - Hour wraps from 23 to 0.
  - Day of week wraps from 6 to 0.
  - Month wraps from 12 to 1 and increments the year.
  - Each wrap carries into the next field in the chain. A day carry advances day of month, day of week and day of year together.
- R5: The packed words hold the following fields:
  - Word 0x14: day of week in [26:24], hour in [20:16], minute in [13:8], second in [5:0].
  - Word 0x18: year in [27:16], month in [11:8], day of month in [4:0].
  - Word 0x1C: day of year in [11:0].
  - All other bits read 0.
- R6: The day of month wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11; 31 for the other months except February; 29 for February when year mod 4 is 0, otherwise 28. The day of year wraps to 1 after 366 in such a leap year and after 365 otherwise.
- R7: Flag bit 0 sets on the second step in which a field changes whose bit is set in the increment enable register. The bit order is second 0, minute 1, hour 2, day of month 3, day of week 4, day of year 5, month 6, year 7.
- R8: Flag bit 1 sets on a second step after which every field whose mask bit is clear equals its alarm register. The mask uses the same bit order as R7. A mask of 0xFF never raises the flag.
- R9: Writing 1 to a bit of the flag register clears that flag. Writing 0 leaves the flag unchanged. `irq` is high whenever either flag is set.
- R10: A counter write takes effect at once and restarts the prescaler from zero. Alarm registers (0x60 + 4*field), calibration (0x40, 18 bits) and the enable and mask registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Reference tick enable, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt, OR of the two flags |

## Verification
The bench sets the time just before midnight on New Year's Eve and steps one second. It expects every field to wrap in a single step. A design that broke the carry chain would leave the year or the day of year unchanged.

The February checks run in a year divisible by four and in a year that is not. A design with a wrong leap rule would stop on day 29 in the wrong year or skip it.

The bench also breaks a prescale period with a counter write. A design that did not restart the divider would advance the second counter early.

The flag tests cover the following cases:
- An enabled field that does not change must leave the increment flag clear.
- A masked field that mismatches must still let the alarm fire.
- A mask of all ones must keep the alarm silent.
- Writing zeros to the flag register must not clear a flag.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int NUM_FIELDS = 8;
    localparam int FIELD_W    = 12;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DOM  = 3;
    localparam int F_DOW  = 4;
    localparam int F_DOY  = 5;
    localparam int F_MON  = 6;
    localparam int F_YEAR = 7;

    typedef logic [NUM_FIELDS-1:0][FIELD_W-1:0] field_vec_t;

    typedef enum logic [1:0] {
        PS_STOPPED = 2'd0,
        PS_HELD    = 2'd1,
        PS_RUNNING = 2'd2
    } ps_state_t;

    function automatic int field_width(input int idx);
        case (idx)
            F_SEC, F_MIN:   return 6;
            F_HOUR, F_DOM:  return 5;
            F_DOW:          return 3;
            F_MON:          return 4;
            default:        return 12;
        endcase
    endfunction

    function automatic logic [FIELD_W-1:0] field_mask(input int idx);
        return {FIELD_W{1'b1}} >> (FIELD_W - field_width(idx));
    endfunction

    function automatic logic is_leap(input logic [FIELD_W-1:0] year);
        return (year[1:0] == 2'b00);
    endfunction

    function automatic logic [FIELD_W-1:0] month_days(input logic [FIELD_W-1:0] mon,
                                                       input logic [FIELD_W-1:0] year);
        case (mon)
            12'd2:                      return is_leap(year) ? 12'd29 : 12'd28;
            12'd4, 12'd6, 12'd9, 12'd11: return 12'd30;
            default:                    return 12'd31;
        endcase
    endfunction

    function automatic logic [FIELD_W-1:0] year_days(input logic [FIELD_W-1:0] year);
        return is_leap(year) ? 12'd366 : 12'd365;
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    input  logic div_hold,
    input  logic restart,
    output logic sec_pulse
);
    localparam int DIV_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PRESCALE - 1);

    ps_state_t        state_q, state_d;
    logic [DIV_W-1:0] div_q;

    // Next-state choice: HOLD wins over START and STOP.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_STOPPED: begin
                if (div_hold)    state_d = PS_HELD;       // HOLD
                else if (enable) state_d = PS_RUNNING;    // START
            end
            PS_RUNNING: begin
                if (div_hold)     state_d = PS_HELD;      // HOLD
                else if (!enable) state_d = PS_STOPPED;   // STOP
            end
            PS_HELD: begin
                if (!div_hold) state_d = enable ? PS_RUNNING : PS_STOPPED; // RELEASE
            end
            default: state_d = PS_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_STOPPED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               div_q <= '0;
        else if (state_q != PS_RUNNING || restart) div_q <= '0;
        else if (tick)                            div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
    end

    always_comb begin
        sec_pulse = 1'b0;
        unique case (state_q)
            PS_RUNNING: sec_pulse = tick && !restart && (div_q == DIV_LAST);
            default:    sec_pulse = 1'b0;
        endcase
    end

    AST_HELD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_HELD) |=> (div_q == '0)); // R3
    AST_STOPPED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_STOPPED) |-> !sec_pulse); // R2
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  logic [NUM_FIELDS-1:0] wr_sel,
    input  logic [FIELD_W-1:0]    wr_val,
    output field_vec_t            cur,
    output field_vec_t            nxt,
    output logic [NUM_FIELDS-1:0] changed
);
    field_vec_t fld_q;
    logic c_min, c_hour, c_day, c_mon, c_year;

    // Calendar step: post-step values and the set of fields that move.
    always_comb begin
        nxt     = fld_q;
        changed = '0;
        c_min   = 1'b0;
        c_hour  = 1'b0;
        c_day   = 1'b0;
        c_mon   = 1'b0;
        c_year  = 1'b0;

        changed[F_SEC] = 1'b1;
        if (fld_q[F_SEC] >= 12'd59) begin
            nxt[F_SEC] = '0;
            c_min      = 1'b1;
        end else begin
            nxt[F_SEC] = fld_q[F_SEC] + 12'd1;
        end

        if (c_min) begin
            changed[F_MIN] = 1'b1;
            if (fld_q[F_MIN] >= 12'd59) begin
                nxt[F_MIN] = '0;
                c_hour     = 1'b1;
            end else begin
                nxt[F_MIN] = fld_q[F_MIN] + 12'd1;
            end
        end

        if (c_hour) begin
            changed[F_HOUR] = 1'b1;
            if (fld_q[F_HOUR] >= 12'd23) begin
                nxt[F_HOUR] = '0;
                c_day       = 1'b1;
            end else begin
                nxt[F_HOUR] = fld_q[F_HOUR] + 12'd1;
            end
        end

        if (c_day) begin
            changed[F_DOM] = 1'b1;
            changed[F_DOW] = 1'b1;
            changed[F_DOY] = 1'b1;
            nxt[F_DOW] = (fld_q[F_DOW] >= 12'd6) ? '0 : fld_q[F_DOW] + 12'd1;
            nxt[F_DOY] = (fld_q[F_DOY] >= year_days(fld_q[F_YEAR])) ? 12'd1
                                                                     : fld_q[F_DOY] + 12'd1;
            if (fld_q[F_DOM] >= month_days(fld_q[F_MON], fld_q[F_YEAR])) begin
                nxt[F_DOM] = 12'd1;
                c_mon      = 1'b1;
            end else begin
                nxt[F_DOM] = fld_q[F_DOM] + 12'd1;
            end
        end

        if (c_mon) begin
            changed[F_MON] = 1'b1;
            if (fld_q[F_MON] >= 12'd12) begin
                nxt[F_MON] = 12'd1;
                c_year     = 1'b1;
            end else begin
                nxt[F_MON] = fld_q[F_MON] + 12'd1;
            end
        end

        if (c_year) begin
            changed[F_YEAR] = 1'b1;
            nxt[F_YEAR]     = fld_q[F_YEAR] + 12'd1;
        end
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam logic [FIELD_W-1:0] RST_VAL =
            (i == F_DOM || i == F_DOY || i == F_MON) ? 12'd1 : 12'd0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         fld_q[i] <= RST_VAL;
            else if (wr_sel[i]) fld_q[i] <= wr_val & field_mask(i);
            else if (step)      fld_q[i] <= nxt[i];
        end
    end

    assign cur = fld_q;

    AST_SEC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wr_sel == '0 && fld_q[F_SEC] < 12'd59)
        |=> fld_q[F_SEC] == $past(fld_q[F_SEC]) + 12'd1); // R2
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && wr_sel == '0) |=> $stable(fld_q)); // R2
    AST_DAY_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wr_sel == '0 && fld_q[F_SEC] == 12'd59 && fld_q[F_MIN] == 12'd59
         && fld_q[F_HOUR] == 12'd23)
        |=> (fld_q[F_HOUR] == '0) && (fld_q[F_DOM] != $past(fld_q[F_DOM]))); // R4
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step,
    input  field_vec_t            nxt,
    input  logic [NUM_FIELDS-1:0] changed,
    input  field_vec_t            alarm,
    input  logic [NUM_FIELDS-1:0] mask,
    input  logic [NUM_FIELDS-1:0] inc_en,
    input  logic                  clr_we,
    input  logic [1:0]            clr_bits,
    output logic [1:0]            flags,
    output logic                  irq
);
    logic [NUM_FIELDS-1:0] eq;
    logic                  alarm_hit, inc_hit;
    logic [1:0]            flags_q;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
        assign eq[i] = mask[i] || (nxt[i] == alarm[i]);
    end

    assign alarm_hit = step && (mask != '1) && (&eq);
    assign inc_hit   = step && |(changed & inc_en);

    // Set wins over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~(clr_we ? clr_bits : 2'b00)) | {alarm_hit, inc_hit};
        end
    end

    assign flags = flags_q;
    assign irq   = |flags_q;

    AST_MASK_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |=> !$rose(flags_q[1])); // R8
    AST_W1C_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_bits[0] && !inc_hit) |=> !flags_q[0]); // R9
    AST_INC_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en == '0) |=> !$rose(flags_q[0])); // R7
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int PRESCALE = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_en,
    input  logic [6:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);
    localparam logic [6:0] A_FLAGS = 7'h00;
    localparam logic [6:0] A_CTRL  = 7'h08;
    localparam logic [6:0] A_INCEN = 7'h0C;
    localparam logic [6:0] A_MASK  = 7'h10;
    localparam logic [6:0] A_PACK0 = 7'h14;
    localparam logic [6:0] A_PACK1 = 7'h18;
    localparam logic [6:0] A_PACK2 = 7'h1C;
    localparam logic [6:0] A_CAL   = 7'h40;
    localparam int CAL_W = 18;

    logic [2:0]            ctrl_q;   // {cal_off, div_hold, enable}
    logic [CAL_W-1:0]      cal_q;
    logic [NUM_FIELDS-1:0] mask_q, incen_q;
    field_vec_t            alarm_q, cur, nxt;
    logic [NUM_FIELDS-1:0] changed, cnt_sel;
    logic [1:0]            flags;
    logic                  sec_pulse, cnt_region, alm_region;
    logic [2:0]            fidx;

    assign fidx       = addr[4:2];
    assign cnt_region = (addr[6:5] == 2'b01) && (addr[1:0] == 2'b00);
    assign alm_region = (addr[6:5] == 2'b11) && (addr[1:0] == 2'b00);

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_sel
        assign cnt_sel[i] = wr_en && cnt_region && (fidx == 3'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                alarm_q[i] <= '0;
            else if (wr_en && alm_region && fidx == 3'(i))
                alarm_q[i] <= wdata[FIELD_W-1:0] & field_mask(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            cal_q   <= '0;
            mask_q  <= '1;
            incen_q <= '0;
        end else if (wr_en) begin
            if (addr == A_CTRL)  ctrl_q  <= {wdata[4], wdata[1], wdata[0]};
            if (addr == A_CAL)   cal_q   <= wdata[CAL_W-1:0];
            if (addr == A_MASK)  mask_q  <= wdata[NUM_FIELDS-1:0];
            if (addr == A_INCEN) incen_q <= wdata[NUM_FIELDS-1:0];
        end
    end

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .enable    (ctrl_q[0]),
        .div_hold  (ctrl_q[1]),
        .restart   (|cnt_sel),
        .sec_pulse (sec_pulse)
    );

    rtc_time_chain u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (sec_pulse),
        .wr_sel  (cnt_sel),
        .wr_val  (wdata[FIELD_W-1:0]),
        .cur     (cur),
        .nxt     (nxt),
        .changed (changed)
    );

    rtc_alarm_irq u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (sec_pulse),
        .nxt      (nxt),
        .changed  (changed),
        .alarm    (alarm_q),
        .mask     (mask_q),
        .inc_en   (incen_q),
        .clr_we   (wr_en && addr == A_FLAGS),
        .clr_bits (wdata[1:0]),
        .flags    (flags),
        .irq      (irq)
    );

    always_comb begin
        rdata = '0;
        if (cnt_region)      rdata = {20'd0, cur[fidx]};
        else if (alm_region) rdata = {20'd0, alarm_q[fidx]};
        else begin
            case (addr)
                A_FLAGS: rdata = {30'd0, flags};
                A_CTRL:  rdata = {27'd0, ctrl_q[2], 2'b00, ctrl_q[1], ctrl_q[0]};
                A_INCEN: rdata = {24'd0, incen_q};
                A_MASK:  rdata = {24'd0, mask_q};
                A_PACK0: rdata = {5'd0, cur[F_DOW][2:0], 3'd0, cur[F_HOUR][4:0],
                                  2'd0, cur[F_MIN][5:0], 2'd0, cur[F_SEC][5:0]};
                A_PACK1: rdata = {4'd0, cur[F_YEAR], 4'd0, cur[F_MON][3:0],
                                  3'd0, cur[F_DOM][4:0]};
                A_PACK2: rdata = {20'd0, cur[F_DOY]};
                A_CAL:   rdata = {14'd0, cal_q};
                default: rdata = '0;
            endcase
        end
    end

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 7'h20) |=> cur[F_SEC] == ($past(wdata[FIELD_W-1:0]) & 12'h03F)); // R10
    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[1] |=> !sec_pulse); // R3
endmodule

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;
    localparam int PS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    rtc_calendar #(.PRESCALE(PS)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    task automatic set_time(input int yr, input int mo, input int dm, input int dw,
                            input int dy, input int hr, input int mi, input int se);
        wr(7'h20, 0);
        wr(7'h3C, yr); wr(7'h38, mo); wr(7'h2C, dm); wr(7'h30, dw);
        wr(7'h34, dy); wr(7'h28, hr); wr(7'h24, mi); wr(7'h20, se);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(7'h20, d); check("R1", "sec", d, 0);
        rd(7'h2C, d); check("R1", "dom", d, 1);
        rd(7'h38, d); check("R1", "month", d, 1);
        rd(7'h34, d); check("R1", "doy", d, 1);
        rd(7'h10, d); check("R1", "mask", d, 32'hFF);
        rd(7'h00, d); check("R1", "flags", d, 0);
        rd(7'h08, d); check("R1", "ctrl", d, 0);
        check("R1", "irq", {31'd0, irq}, 0);
    endtask

    task automatic t_disabled_and_prescale();
        logic [31:0] d;
        ticks(3 * PS);
        rd(7'h20, d); check("R2", "no count while disabled", d, 0);
        wr(7'h08, 1);
        ticks(PS);
        rd(7'h20, d); check("R2", "one second per PRESCALE ticks", d, 1);
        ticks(PS - 1);
        rd(7'h20, d); check("R2", "partial period no advance", d, 1);
        ticks(1);
        rd(7'h20, d); check("R2", "period completes", d, 2);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        wr(7'h08, 32'h13);
        rd(7'h08, d); check("R3", "ctrl readback", d, 32'h13);
        ticks(3 * PS);
        rd(7'h20, d); check("R3", "held divider no advance", d, 2);
        wr(7'h08, 1);
    endtask

    task automatic t_restart();
        logic [31:0] d;
        wr(7'h20, 10);
        ticks(PS - 1);
        wr(7'h24, 7);
        ticks(PS - 1);
        rd(7'h20, d); check("R10", "write restarts prescaler", d, 10);
        ticks(1);
        rd(7'h20, d); check("R10", "advance after full period", d, 11);
        rd(7'h24, d); check("R10", "minute written", d, 7);
    endtask

    task automatic t_new_year();
        logic [31:0] d;
        set_time(2023, 12, 31, 6, 365, 23, 59, 59);
        ticks(PS);
        rd(7'h20, d); check("R4", "sec wrap", d, 0);
        rd(7'h24, d); check("R4", "min wrap", d, 0);
        rd(7'h28, d); check("R4", "hour wrap", d, 0);
        rd(7'h30, d); check("R4", "dow wrap", d, 0);
        rd(7'h38, d); check("R4", "month wrap", d, 1);
        rd(7'h3C, d); check("R4", "year inc", d, 2024);
        rd(7'h18, d); check("R5", "packed word 1", d, 32'h07E8_0101);
        rd(7'h1C, d); check("R6", "doy wrap 365", d, 1);
    endtask

    task automatic t_february();
        logic [31:0] d;
        set_time(2024, 2, 28, 3, 59, 23, 59, 59);
        ticks(PS);
        rd(7'h2C, d); check("R6", "leap feb 29", d, 29);
        rd(7'h34, d); check("R6", "leap doy 60", d, 60);
        rd(7'h14, d); check("R5", "packed word 0", d, 32'h0400_0000);
        set_time(2024, 2, 29, 4, 60, 23, 59, 58);
        ticks(PS);
        rd(7'h14, d); check("R5", "packed word 0 sec", d, 32'h0417_3B3B);
        ticks(PS);
        rd(7'h18, d); check("R6", "leap feb -> mar 1", d, 32'h07E8_0301);
        set_time(2023, 2, 28, 1, 59, 23, 59, 59);
        ticks(PS);
        rd(7'h18, d); check("R6", "non-leap feb -> mar 1", d, 32'h07E7_0301);
        set_time(2023, 4, 30, 1, 120, 23, 59, 59);
        ticks(PS);
        rd(7'h18, d); check("R6", "april 30 -> may 1", d, 32'h07E7_0501);
    endtask

    task automatic t_increment();
        logic [31:0] d;
        wr(7'h00, 3);
        wr(7'h0C, 32'h02);
        rd(7'h0C, d); check("R10", "incen readback", d, 2);
        wr(7'h20, 58);
        ticks(PS);
        rd(7'h00, d); check("R7", "no flag without minute change", d, 0);
        ticks(PS);
        rd(7'h00, d); check("R7", "increment flag on minute", d, 1);
        check("R9", "irq with inc flag", {31'd0, irq}, 1);
        wr(7'h00, 0);
        rd(7'h00, d); check("R9", "write 0 keeps flag", d, 1);
        wr(7'h00, 1);
        rd(7'h00, d); check("R9", "w1c clears", d, 0);
        check("R9", "irq low after clear", {31'd0, irq}, 0);
        wr(7'h0C, 0);
    endtask

    task automatic t_alarm();
        logic [31:0] d;
        wr(7'h60, 5);
        wr(7'h68, 9);
        rd(7'h60, d); check("R10", "alarm sec readback", d, 5);
        wr(7'h10, 32'hFE);
        wr(7'h20, 3);
        ticks(PS);
        rd(7'h00, d); check("R8", "no alarm before match", d, 0);
        ticks(PS);
        rd(7'h00, d); check("R8", "alarm on sec match", d, 2);
        check("R9", "irq with alarm", {31'd0, irq}, 1);
        wr(7'h00, 2);
        wr(7'h10, 32'hFA);
        wr(7'h28, 3);
        wr(7'h20, 4);
        ticks(PS);
        rd(7'h00, d); check("R8", "hour mismatch blocks alarm", d, 0);
        wr(7'h10, 32'hFF);
        wr(7'h20, 4);
        ticks(PS);
        rd(7'h00, d); check("R8", "mask 0xFF disables", d, 0);
        wr(7'h40, 32'hFFFF_FFFF);
        rd(7'h40, d); check("R10", "calibration 18 bits", d, 32'h3FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled_and_prescale();
        t_hold();
        t_restart();
        t_new_year();
        t_february();
        t_increment();
        t_alarm();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule